// File: doc/BRIEF.md
# Lattice Gas Site Update Unit

This block computes the next particle state of a single lattice site on every clock cycle. Each site holds six direction bits, one per direction of travel on a hexagonal neighbourhood that is laid out on a rectangular grid with 45-degree diagonals. A 1 means a particle of unit mass and unit speed is moving in that direction. Bit i stands for direction i, counting counter-clockwise from 0 to 5, and direction i is opposite direction (i+3) mod 6. A seventh input marks sites on an obstacle outline. This bit is never written back, because obstacles do not move.

On an open site the unit applies a collision rule. The rule keeps the particle count and the momentum, and it is symmetric under rotation and reflection. On an obstacle site every particle bounces straight back. A parity input chooses between the two momentum-equivalent outcomes of a head-on collision. The surrounding system drives parity from odd/even site position or from odd/even sweep number. A valid flag travels through the pipeline alongside the data.

The pipeline has `NUM_STAGES` registers, with a default of 3. The collision and reflection results are formed before the first register and then carried through `NUM_STAGES-1` rule stages. The last stage is the obstacle multiplexer. Reset is asserted asynchronously and released in step with the clock.

Top module: `lgas_site_unit`

## Requirements
- R1: While reset is active, and after its release until the first valid result, out_valid is 0 and out_dirs is 6'b000000.
- R2: out_valid equals in_valid delayed by exactly NUM_STAGES clock cycles (3 by default). A valid result belongs to the inputs sampled NUM_STAGES cycles earlier.
- R3: When in_obst is 1, input bit i appears at output bit (i+3) mod 6 (bounce-back). This holds whatever the value of in_parity.
- R4: When in_obst is 0 and exactly bits i and i+3 are set (a head-on pair), the output is rotated one step. With in_parity 0 the rotation is counter-clockwise: output bit (i+1) mod 6 takes input bit i. With in_parity 1 the rotation is clockwise: output bit i takes input bit (i+1) mod 6.
- R5: When in_obst is 0 and four bits are set whose two clear bits are opposite each other, the output is rotated exactly as in R4, with the same parity rule.
- R6: When in_obst is 0, the state 6'b010101 maps to 6'b101010 and 6'b101010 maps to 6'b010101, for either parity.
- R7: When in_obst is 0, every state not covered by R4 to R6 passes through unchanged, whatever the value of in_parity.
- R8: While out_valid is 0, out_dirs keeps its previous value.
- R9: Every valid output has the same number of set bits as the input it was computed from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | The site inputs are valid this cycle |
| in_dirs | input | 6 | Incoming particle bits, with bit i standing for direction i |
| in_obst | input | 1 | 1 if the site lies on an obstacle outline |
| in_parity | input | 1 | Chooses the outcome of a head-on collision |
| out_valid | output | 1 | out_dirs holds a new result |
| out_dirs | output | 6 | Outgoing particle bits |

## Verification
A valid flag stuck or dropped in one rule stage shows at out_valid exactly NUM_STAGES cycles after the affected input. If that stage's payload enable is wrong, out_dirs shows a stale or wrong value on the next valid result, or a changed value during an idle gap. A corrupted obstacle bit or collision result is visible in the first valid output that depends on it. That output swaps between the bounce-back and collision patterns, or changes its particle count. The reference model compares both outputs on every cycle, so each fault is reported in the cycle where it first reaches the ports.

// File: rtl/lgas_pkg.sv
package lgas_pkg;
  localparam int NDIR  = 6;
  localparam int NHALF = NDIR / 2;
  typedef logic [NDIR-1:0] dirs_t;
  localparam dirs_t TRI_EVEN = 6'b010101;
  localparam dirs_t TRI_ODD  = 6'b101010;
endpackage

// File: rtl/lgas_rst_sync.sv
module lgas_rst_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [DEPTH-1:0] sync_q;
  logic [DEPTH-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[DEPTH-1];
endmodule

// File: rtl/lgas_collide.sv
module lgas_collide
  import lgas_pkg::*;
(
  input  dirs_t dirs_i,
  input  logic  parity_i,
  output dirs_t dirs_o
);
  dirs_t           rot_ccw;
  dirs_t           rot_cw;
  logic [NHALF-1:0] pair_hit;
  logic [NHALF-1:0] hole_hit;

  for (genvar i = 0; i < NDIR; i++) begin : g_rot
    assign rot_ccw[(i+1)%NDIR] = dirs_i[i];
    assign rot_cw[i]           = dirs_i[(i+1)%NDIR];
  end

  for (genvar k = 0; k < NHALF; k++) begin : g_axis
    localparam dirs_t AXIS = dirs_t'((1 << k) | (1 << (k + NHALF)));
    assign pair_hit[k] = (dirs_i == AXIS);
    assign hole_hit[k] = (dirs_i == ~AXIS);
  end

  always_comb begin
    dirs_o = dirs_i;
    if ((|pair_hit) || (|hole_hit)) begin
      dirs_o = parity_i ? rot_cw : rot_ccw;
    end else if (dirs_i == TRI_EVEN) begin
      dirs_o = TRI_ODD;
    end else if (dirs_i == TRI_ODD) begin
      dirs_o = TRI_EVEN;
    end
  end
endmodule

// File: rtl/lgas_bounce.sv
module lgas_bounce
  import lgas_pkg::*;
(
  input  dirs_t dirs_i,
  output dirs_t dirs_o
);
  for (genvar i = 0; i < NDIR; i++) begin : g_flip
    assign dirs_o[(i+NHALF)%NDIR] = dirs_i[i];
  end
endmodule

// File: rtl/lgas_stage.sv
module lgas_stage #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld_i,
  input  logic [W-1:0] data_i,
  output logic         vld_o,
  output logic [W-1:0] data_o
);
  logic         vld_d;
  logic [W-1:0] data_d;

  always_comb begin
    vld_d  = vld_i;
    data_d = data_o;
    if (vld_i) data_d = data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      data_o <= '0;
    end else begin
      vld_o  <= vld_d;
      data_o <= data_d;
    end
  end
endmodule

// File: rtl/lgas_site_unit.sv
module lgas_site_unit
  import lgas_pkg::*;
#(
  parameter int NUM_STAGES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [5:0] in_dirs,
  input  logic       in_obst,
  input  logic       in_parity,
  output logic       out_valid,
  output logic [5:0] out_dirs
);
  localparam int RULE_ST = NUM_STAGES - 1;
  localparam int LANE_W  = 1 + 2 * NDIR;

  logic  rst_sync_n;
  dirs_t coll_w;
  dirs_t refl_w;

  logic                    vld_c [0:RULE_ST];
  logic [LANE_W-1:0]       pay_c [0:RULE_ST];

  lgas_rst_sync #(.DEPTH(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lgas_collide u_coll (
    .dirs_i   (in_dirs),
    .parity_i (in_parity),
    .dirs_o   (coll_w)
  );

  lgas_bounce u_bnc (
    .dirs_i (in_dirs),
    .dirs_o (refl_w)
  );

  assign vld_c[0] = in_valid;
  assign pay_c[0] = {in_obst, coll_w, refl_w};

  for (genvar s = 0; s < RULE_ST; s++) begin : g_stage
    lgas_stage #(.W(LANE_W)) u_stg (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .vld_i  (vld_c[s]),
      .data_i (pay_c[s]),
      .vld_o  (vld_c[s+1]),
      .data_o (pay_c[s+1])
    );
  end

  logic  last_obst;
  dirs_t last_coll;
  dirs_t last_refl;
  logic  out_valid_d;
  dirs_t out_dirs_d;

  assign last_obst = pay_c[RULE_ST][LANE_W-1];
  assign last_coll = pay_c[RULE_ST][2*NDIR-1:NDIR];
  assign last_refl = pay_c[RULE_ST][NDIR-1:0];

  always_comb begin
    out_valid_d = vld_c[RULE_ST];
    out_dirs_d  = out_dirs;
    if (vld_c[RULE_ST]) out_dirs_d = last_obst ? last_refl : last_coll;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid <= 1'b0;
      out_dirs  <= '0;
    end else begin
      out_valid <= out_valid_d;
      out_dirs  <= out_dirs_d;
    end
  end
endmodule

// File: rtl/lgas_site_unit_chk.sv
module lgas_site_unit_chk #(
  parameter int NUM_STAGES = 3
) (
  input logic       clk,
  input logic       rst_sync_n,
  input logic       in_valid,
  input logic [5:0] in_dirs,
  input logic       in_obst,
  input logic       out_valid,
  input logic [5:0] out_dirs
);
  logic       sh_v [0:NUM_STAGES-1];
  logic [5:0] sh_d [0:NUM_STAGES-1];
  logic       sh_o [0:NUM_STAGES-1];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      for (int i = 0; i < NUM_STAGES; i++) begin
        sh_v[i] <= 1'b0;
        sh_d[i] <= '0;
        sh_o[i] <= 1'b0;
      end
    end else begin
      sh_v[0] <= in_valid;
      sh_d[0] <= in_dirs;
      sh_o[0] <= in_obst;
      for (int i = 1; i < NUM_STAGES; i++) begin
        sh_v[i] <= sh_v[i-1];
        sh_d[i] <= sh_d[i-1];
        sh_o[i] <= sh_o[i-1];
      end
    end
  end

  // R2
  p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid == sh_v[NUM_STAGES-1]);

  // R3
  p_bounce_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && sh_o[NUM_STAGES-1]) |->
      out_dirs == {sh_d[NUM_STAGES-1][2:0], sh_d[NUM_STAGES-1][5:3]});

  // R7
  p_single_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && !sh_o[NUM_STAGES-1] && $countones(sh_d[NUM_STAGES-1]) == 1) |->
      out_dirs == sh_d[NUM_STAGES-1]);

  // R8
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !out_valid |-> $stable(out_dirs));

  // R9
  p_count_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> $countones(out_dirs) == $countones(sh_d[NUM_STAGES-1]));
endmodule

bind lgas_site_unit lgas_site_unit_chk #(.NUM_STAGES(NUM_STAGES)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .in_valid   (in_valid),
  .in_dirs    (in_dirs),
  .in_obst    (in_obst),
  .out_valid  (out_valid),
  .out_dirs   (out_dirs)
);

// File: tb/lgas_site_unit_tb_top.sv
module lgas_site_unit_tb_top;
  localparam int LAT = 3;

  logic       clk;
  logic       rst_n;
  logic       in_valid;
  logic [5:0] in_dirs;
  logic       in_obst;
  logic       in_parity;
  logic       out_valid;
  logic [5:0] out_dirs;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  lgas_site_unit #(.NUM_STAGES(LAT)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_dirs   (in_dirs),
    .in_obst   (in_obst),
    .in_parity (in_parity),
    .out_valid (out_valid),
    .out_dirs  (out_dirs)
  );

  initial clk = 1'b0;
  always #2.5ns clk = ~clk;

  // Behavioural expectation, written from the requirements.
  function automatic int ref_next(int d, int ob, int par, output string tag);
    int ones, r, comp;
    ones = 0;
    for (int i = 0; i < 6; i++) ones += (d >> i) & 1;
    comp = (~d) & 63;
    if (ob != 0) begin
      tag = "R3";
      r = 0;
      for (int i = 0; i < 6; i++) if (((d >> i) & 1) != 0) r |= 1 << ((i + 3) % 6);
      return r;
    end
    if ((ones == 2 && (d == 9 || d == 18 || d == 36)) ||
        (ones == 4 && (comp == 9 || comp == 18 || comp == 36))) begin
      tag = (ones == 2) ? "R4" : "R5";
      if (par == 0) return ((d << 1) | (d >> 5)) & 63;
      else          return ((d >> 1) | (d << 5)) & 63;
    end
    if (d == 21) begin tag = "R6"; return 42; end
    if (d == 42) begin tag = "R6"; return 21; end
    tag = "R7";
    return d;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  typedef struct {bit v; int dirs; int ones; string tag;} exp_t;
  exp_t q[$];
  int last_out = 0;

  task automatic step(bit v, int d, int ob, int par);
    exp_t e, got;
    string tg;
    int ones;
    @(negedge clk);
    if (q.size() == LAT) begin
      got = q.pop_front();
      check("R2", int'(out_valid), int'(got.v));
      if (got.v) begin
        check(got.tag, int'(out_dirs), got.dirs);
        ones = 0;
        for (int i = 0; i < 6; i++) ones += out_dirs[i];
        check("R9", ones, got.ones);
        last_out = got.dirs;
      end else begin
        check("R8", int'(out_dirs), last_out);
      end
    end
    in_valid  = v;
    in_dirs   = 6'(d);
    in_obst   = ob[0];
    in_parity = par[0];
    e.v = v;
    e.dirs = ref_next(d, ob, par, tg);
    e.tag = tg;
    e.ones = 0;
    for (int i = 0; i < 6; i++) e.ones += (d >> i) & 1;
    q.push_back(e);
  endtask

  initial begin
    #1000000ns;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_dirs = '0; in_obst = 1'b0; in_parity = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", int'(out_valid), 0);
    check("R1", int'(out_dirs), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R1", int'(out_valid), 0);
    check("R1", int'(out_dirs), 0);
    for (int i = 0; i < LAT; i++) begin
      exp_t z;
      z.v = 0; z.dirs = 0; z.ones = 0; z.tag = "R8";
      q.push_back(z);
    end
    // Full sweep of dirs x obstacle x parity, back to back.
    for (int n = 0; n < 256; n++) step(1, n & 63, (n >> 6) & 1, (n >> 7) & 1);
    // Same sweep with idle gaps.
    for (int n = 0; n < 256; n++) begin
      step(1, n & 63, (n >> 6) & 1, (n >> 7) & 1);
      if (n % 5 == 2) step(0, 63 - (n & 63), 1, 0);
    end
    // Collision states under both parities, interleaved with obstacles.
    for (int n = 0; n < 8; n++) begin
      step(1, 9,  0, n & 1);  step(1, 18, 0, n & 1);  step(1, 36, 0, n & 1);
      step(1, 54, 0, n & 1);  step(1, 45, 0, n & 1);  step(1, 27, 0, n & 1);
      step(1, 21, 0, n & 1);  step(1, 42, 1, n & 1);
    end
    // Random traffic.
    for (int n = 0; n < 2000; n++) begin
      int r;
      r = int'($urandom());
      step(((r >> 10) & 3) != 0, r & 63, (r >> 6) & 1, (r >> 7) & 1);
    end
    for (int n = 0; n < LAT + 2; n++) step(0, 0, 0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule